// File: doc/BRIEF.md
# Power-Path Protection and Fault Sequencer

This block is a digital supervisor that controls the power-path switch enables and the charger enable of a battery power system. Every input is already a digital flag. One says the supply is above its undervoltage lockout. Two come from comparators: one for short-circuit current and one for a low output voltage. One is an emergency shutdown request. One reports a power failure. The last two are write strobes decoded by a serial register interface: one for a write to the power-path control register and one for a charge request. A free-running prescaler turns the system clock into a 1 ms tick. Every timing window is counted in these ticks.

The switches turn on only after the supply has been good for longer than the power-up delay. A short-circuit or low-voltage condition that lasts longer than the persistence window turns every switch off and sets a sticky fault bit. That bit holds until all power is removed, which the block sees as the supply-good flag going false. The emergency shutdown acts the same way at once and also sets the power-fail status bit. Power-fail reports are debounced: the status bit is set only on the third reported event. Writing the power-path register clears the count.

Top module: `pwrpath_supervisor`

## Requirements
- R1: While reset is asserted, and until the first qualifying event afterwards, all switch enables, the charger enable, the fault bit and the power-fail status bit read 0.
- R2: Once `uvlo_ok_i` rises, all switch enables stay 0 until the flag has been continuously 1 for more than POWERUP_MS ticks. Within about one tick after that they all read 1.
- R3: When `uvlo_ok_i` is 0 at a clock edge, all switch enables read 0 after that edge. A later rise of the flag starts a fresh power-up delay.
- R4: If `sc_cmp_i` stays at 1 for more than PERSIST_MS ticks, all switch enables go to 0 and `fault_o` goes to 1. A shorter assertion has no effect on any output.
- R5: If `lowv_cmp_i` stays at 1 for more than PERSIST_MS ticks, the response is the same as in R4.
- R6: A short-circuit or low-voltage condition that drops for a single clock restarts its persistence window from zero. Two sub-window assertions separated by one low cycle therefore do not set the fault.
- R7: Once set, `fault_o` stays 1 and the switches stay off while `uvlo_ok_i` is 1. The bit clears at the first edge where `uvlo_ok_i` and `fast_off_i` are both 0.
- R8: `chg_en_o` is set only by a `chg_req_i` strobe while `uvlo_ok_i` is 1 and no fault is present. A fault or a loss of `uvlo_ok_i` clears it. After a recovery it stays 0 until a new request arrives.
- R9: `fast_off_i` at a clock edge drives all switch enables to 0 and sets both `fault_o` and `pf_stat_o` at that edge. The switches return only after `fast_off_i` has gone to 0, `uvlo_ok_i` has dropped and risen again, and a fresh power-up delay has passed.
- R10: Each 0-to-1 transition of `pwr_fail_i` counts as one power-fail event. `pf_stat_o` becomes 1 at the edge that sees the third event and not before.
- R11: A `pp_wr_i` strobe clears the power-fail event count and `pf_stat_o`, unless `fast_off_i` is asserted in the same cycle. A write in the same cycle as an event discards that event.
- R12: When a fault condition is present in a cycle where the switches would otherwise turn on, the switches stay off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| uvlo_ok_i | input | 1 | Supply above undervoltage lockout |
| sc_cmp_i | input | 1 | Short-circuit current comparator |
| lowv_cmp_i | input | 1 | Output-below-minimum comparator |
| fast_off_i | input | 1 | Emergency shutdown request |
| pwr_fail_i | input | 1 | Power-fail indication; each rise is an event |
| pp_wr_i | input | 1 | Strobe: power-path control register written |
| chg_req_i | input | 1 | Strobe: charge request written |
| sw_en_o | output | NUM_SW | Power-path switch enables |
| chg_en_o | output | 1 | Charger enable |
| fault_o | output | 1 | Sticky fault status |
| pf_stat_o | output | 1 | Sticky power-fail status |

## Verification
A persistence timer that fails to clear would show as a fault after two short, separated comparator pulses. That would appear one tick after the second pulse has lasted long enough. A power-up counter that does not restart would turn the switches on well before the full delay after a supply cycle. A fault latch that clears too early would show as switches returning while the supply flag stays good. An off-by-one in the strike counter would change `pf_stat_o` one cycle after the second or fourth event instead of the third. That is observed against a cycle-accurate count of events and writes kept by the bench.

// File: rtl/pps_pkg.sv
package pps_pkg;

  // Sources that force the power path off in the current cycle.
  typedef struct packed {
    logic fast;
    logic lowv;
    logic sc;
  } trip_t;

  localparam int unsigned NUM_PERSIST = 2;

  function automatic logic trip_any(input trip_t t);
    return t.fast | t.lowv | t.sc;
  endfunction

endpackage

// File: rtl/pps_tick.sv
// Free-running prescaler: one-cycle tick every DIV clocks.
module pps_tick #(
  parameter int unsigned DIV = 125000
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick_o
);
  localparam int unsigned W = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [W-1:0] LAST = W'(DIV - 1);

  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;

  assign tick_o = (cnt_q == LAST);

  always_comb begin
    cnt_d = cnt_q + 1'b1;
    if (tick_o) cnt_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/pps_persist.sv
// Persistence timer: done when cond_i has held through LIMIT+1 ticks.
module pps_persist #(
  parameter int unsigned LIMIT = 15
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic cond_i,
  output logic done_o
);
  localparam int unsigned MAXC = LIMIT + 1;
  localparam int unsigned W = $clog2(MAXC + 1);
  localparam logic [W-1:0] TOP = W'(MAXC);

  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;
  logic         cnt_en;

  assign done_o = cond_i && (cnt_q == TOP);

  always_comb begin
    cnt_en = 1'b0;
    cnt_d  = cnt_q;
    if (!cond_i) begin
      cnt_en = (cnt_q != '0);
      cnt_d  = '0;
    end else if (tick_i && (cnt_q != TOP)) begin
      cnt_en = 1'b1;
      cnt_d  = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/pps_strike.sv
// Counts rising edges of ev_i; hit_o flags the STRIKES-th one.
module pps_strike #(
  parameter int unsigned STRIKES = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ev_i,
  input  logic clr_i,
  output logic hit_o
);
  localparam int unsigned W = $clog2(STRIKES + 1);
  localparam logic [W-1:0] FULL = W'(STRIKES);
  localparam logic [W-1:0] PRE  = W'(STRIKES - 1);

  logic         prev_q;
  logic         rise;
  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;
  logic         cnt_en;

  assign rise  = ev_i && !prev_q;
  assign hit_o = rise && !clr_i && (cnt_q == PRE);

  always_comb begin
    cnt_en = 1'b0;
    cnt_d  = cnt_q;
    if (clr_i) begin
      cnt_en = 1'b1;
      cnt_d  = '0;
    end else if (rise && (cnt_q != FULL)) begin
      cnt_en = 1'b1;
      cnt_d  = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      prev_q <= ev_i;
      if (cnt_en) cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/pwrpath_supervisor.sv
module pwrpath_supervisor
  import pps_pkg::*;
#(
  parameter int unsigned CLK_PER_MS = 125000,
  parameter int unsigned PERSIST_MS = 15,
  parameter int unsigned POWERUP_MS = 250,
  parameter int unsigned PF_STRIKES = 3,
  parameter int unsigned NUM_SW     = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              uvlo_ok_i,
  input  logic              sc_cmp_i,
  input  logic              lowv_cmp_i,
  input  logic              fast_off_i,
  input  logic              pwr_fail_i,
  input  logic              pp_wr_i,
  input  logic              chg_req_i,
  output logic [NUM_SW-1:0] sw_en_o,
  output logic              chg_en_o,
  output logic              fault_o,
  output logic              pf_stat_o
);

  // Reset: asserted asynchronously, released through two flops.
  logic [1:0] rst_sync_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sync_n = rst_sync_q[1];

  // Millisecond tick.
  logic tick;
  pps_tick #(.DIV(CLK_PER_MS)) u_tick (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .tick_o (tick)
  );

  // Persistence timers for the two comparator faults.
  logic [NUM_PERSIST-1:0] pers_cond;
  logic [NUM_PERSIST-1:0] pers_done;
  assign pers_cond = {lowv_cmp_i, sc_cmp_i};

  for (genvar g = 0; g < NUM_PERSIST; g++) begin : g_persist
    pps_persist #(.LIMIT(PERSIST_MS)) u_pers (
      .clk    (clk),
      .rst_n  (rst_sync_n),
      .tick_i (tick),
      .cond_i (pers_cond[g]),
      .done_o (pers_done[g])
    );
  end

  // Power-up delay timer.
  logic pwrup_done;
  pps_persist #(.LIMIT(POWERUP_MS)) u_pwrup (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .tick_i (tick),
    .cond_i (uvlo_ok_i),
    .done_o (pwrup_done)
  );

  // Power-fail strike counter.
  logic pf_hit;
  pps_strike #(.STRIKES(PF_STRIKES)) u_strike (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .ev_i  (pwr_fail_i),
    .clr_i (pp_wr_i),
    .hit_o (pf_hit)
  );

  // Next-state logic.
  trip_t trip;
  logic  trip_now;
  logic  fault_q, fault_d, fault_en;
  logic  chg_q, chg_d, chg_en, chg_block;
  logic  pf_q, pf_d, pf_en;
  logic  sw_on_d;

  always_comb begin
    trip.sc   = pers_done[0];
    trip.lowv = pers_done[1];
    trip.fast = fast_off_i;
    trip_now  = trip_any(trip);

    // Sticky fault: a trip wins over a clear.
    fault_en = 1'b0;
    fault_d  = fault_q;
    if (trip_now) begin
      fault_en = !fault_q;
      fault_d  = 1'b1;
    end else if (!uvlo_ok_i && !fast_off_i) begin
      fault_en = fault_q;
      fault_d  = 1'b0;
    end

    // Switches: on only after power-up with no fault, now or latched.
    sw_on_d = pwrup_done && !fault_q && !trip_now;

    // Charger: a request sets it, any blocking condition clears it.
    chg_block = !uvlo_ok_i || fault_q || trip_now;
    chg_en    = chg_block || chg_req_i;
    chg_d     = !chg_block;

    // Power-fail status: the write clears it unless shutdown is asserted.
    pf_en = pp_wr_i || pf_hit || fast_off_i;
    pf_d  = pp_wr_i ? fast_off_i : 1'b1;
  end

  // Registers.
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      fault_q <= 1'b0;
      chg_q   <= 1'b0;
      pf_q    <= 1'b0;
    end else begin
      if (fault_en) fault_q <= fault_d;
      if (chg_en)   chg_q   <= chg_d;
      if (pf_en)    pf_q    <= pf_d;
    end
  end

  logic [NUM_SW-1:0] sw_q;
  for (genvar s = 0; s < NUM_SW; s++) begin : g_sw
    always_ff @(posedge clk or negedge rst_sync_n) begin
      if (!rst_sync_n)           sw_q[s] <= 1'b0;
      else if (sw_q[s] != sw_on_d) sw_q[s] <= sw_on_d;
    end
  end

  assign sw_en_o   = sw_q;
  assign chg_en_o  = chg_q;
  assign fault_o   = fault_q;
  assign pf_stat_o = pf_q;

endmodule

// File: rtl/pps_checker.sv
module pps_checker #(
  parameter int unsigned NUM_SW = 3
) (
  input logic              clk,
  input logic              rst_q_n,
  input logic              uvlo_ok_i,
  input logic              fast_off_i,
  input logic              pp_wr_i,
  input logic [NUM_SW-1:0] sw_en_o,
  input logic              chg_en_o,
  input logic              fault_o,
  input logic              pf_stat_o
);

  AST_NO_SUPPLY_NO_SW: assert property (@(posedge clk) disable iff (!rst_q_n)
    !uvlo_ok_i |=> (sw_en_o == '0));  // R3

  AST_FAULT_HOLDS_SW_OFF: assert property (@(posedge clk) disable iff (!rst_q_n)
    fault_o |-> (sw_en_o == '0));  // R7

  AST_FAULT_STICKY: assert property (@(posedge clk) disable iff (!rst_q_n)
    (fault_o && uvlo_ok_i) |=> fault_o);  // R7

  AST_FAULT_BLOCKS_CHG: assert property (@(posedge clk) disable iff (!rst_q_n)
    fault_o |-> !chg_en_o);  // R8

  AST_FAST_OFF: assert property (@(posedge clk) disable iff (!rst_q_n)
    fast_off_i |=> ((sw_en_o == '0) && fault_o && pf_stat_o));  // R9

  AST_PF_WRITE_CLEARS: assert property (@(posedge clk) disable iff (!rst_q_n)
    (pp_wr_i && !fast_off_i) |=> !pf_stat_o);  // R11

  AST_SW_TOGETHER: assert property (@(posedge clk) disable iff (!rst_q_n)
    (sw_en_o == '0) || (sw_en_o == '1));  // R12

endmodule

bind pwrpath_supervisor pps_checker #(.NUM_SW(NUM_SW)) i_pps_checker (
  .clk        (clk),
  .rst_q_n    (rst_sync_n),
  .uvlo_ok_i  (uvlo_ok_i),
  .fast_off_i (fast_off_i),
  .pp_wr_i    (pp_wr_i),
  .sw_en_o    (sw_en_o),
  .chg_en_o   (chg_en_o),
  .fault_o    (fault_o),
  .pf_stat_o  (pf_stat_o)
);

// File: tb/test_pwrpath_supervisor.sv
`timescale 1ns/1ps
module test_pwrpath_supervisor;
  localparam int unsigned CPM  = 4;
  localparam int unsigned PERS = 15;
  localparam int unsigned PUP  = 20;
  localparam int unsigned NSW  = 3;

  logic clk = 1'b0;
  logic rst_n;
  logic uvlo_ok, sc_cmp, lowv_cmp, fast_off, pwr_fail, pp_wr, chg_req;
  logic [NSW-1:0] sw_en;
  logic chg_en, fault, pf_stat;

  int n_cmp = 0;
  int n_err = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  pwrpath_supervisor #(
    .CLK_PER_MS(CPM), .PERSIST_MS(PERS), .POWERUP_MS(PUP),
    .PF_STRIKES(3), .NUM_SW(NSW)
  ) i_pwrpath_supervisor (
    .clk(clk), .rst_n(rst_n), .uvlo_ok_i(uvlo_ok), .sc_cmp_i(sc_cmp),
    .lowv_cmp_i(lowv_cmp), .fast_off_i(fast_off), .pwr_fail_i(pwr_fail),
    .pp_wr_i(pp_wr), .chg_req_i(chg_req), .sw_en_o(sw_en),
    .chg_en_o(chg_en), .fault_o(fault), .pf_stat_o(pf_stat)
  );

  function automatic logic [NSW-1:0] exp_sw(input bit on);
    return on ? {NSW{1'b1}} : {NSW{1'b0}};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
  endtask

  // Cycles that always cover more than PUP (or PERS) ticks, plus register delay.
  localparam int unsigned UP_WAIT   = (PUP + 1) * CPM + 3;
  localparam int unsigned TRIP_WAIT = (PERS + 1) * CPM + 3;

  task automatic power_cycle();
    uvlo_ok = 1'b0;
    step(1);
    uvlo_ok = 1'b1;
    step(UP_WAIT);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_err++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; uvlo_ok = 1'b0; sc_cmp = 1'b0; lowv_cmp = 1'b0;
    fast_off = 1'b0; pwr_fail = 1'b0; pp_wr = 1'b0; chg_req = 1'b0;
    step(3);
    check("R1 sw in reset", sw_en, exp_sw(0));
    check("R1 flags in reset", {chg_en, fault, pf_stat}, 3'b000);
    rst_n = 1'b1;
    step(5);
    check("R1 sw after reset", sw_en, exp_sw(0));
    check("R1 flags after reset", {chg_en, fault, pf_stat}, 3'b000);

    // R2 power-up delay
    uvlo_ok = 1'b1;
    step(PUP * CPM);
    check("R2 sw still off at delay", sw_en, exp_sw(0));
    step(UP_WAIT - PUP * CPM);
    check("R2 sw on after delay", sw_en, exp_sw(1));

    // R8 charge request
    chg_req = 1'b1; step(1); chg_req = 1'b0;
    check("R8 charge on request", chg_en, 1);

    // R4 short pulse has no effect
    sc_cmp = 1'b1; step(PERS * CPM); sc_cmp = 1'b0; step(2);
    check("R4 short pulse fault", fault, 0);
    check("R4 short pulse sw", sw_en, exp_sw(1));

    // R6 interrupted condition restarts window
    lowv_cmp = 1'b1; step(PERS * CPM);
    lowv_cmp = 1'b0; step(1);
    lowv_cmp = 1'b1; step(PERS * CPM);
    lowv_cmp = 1'b0; step(2);
    check("R6 restart no fault", fault, 0);
    check("R6 restart sw", sw_en, exp_sw(1));

    // R4 long short-circuit trips
    sc_cmp = 1'b1; step(TRIP_WAIT);
    check("R4 trip fault", fault, 1);
    check("R4 trip sw", sw_en, exp_sw(0));
    check("R8 trip clears charge", chg_en, 0);
    sc_cmp = 1'b0; step(UP_WAIT);
    check("R7 fault sticky", fault, 1);
    check("R7 sw stay off", sw_en, exp_sw(0));
    chg_req = 1'b1; step(1); chg_req = 1'b0;
    check("R8 request ignored in fault", chg_en, 0);

    // R7 / R3 recovery by power cycle
    uvlo_ok = 1'b0; step(1);
    check("R7 fault clears on supply loss", fault, 0);
    check("R3 sw off on supply loss", sw_en, exp_sw(0));
    uvlo_ok = 1'b1; step(PUP * CPM);
    check("R3 fresh delay", sw_en, exp_sw(0));
    step(UP_WAIT - PUP * CPM);
    check("R3 sw back on", sw_en, exp_sw(1));
    check("R8 no charge without request", chg_en, 0);
    chg_req = 1'b1; step(1); chg_req = 1'b0;
    check("R8 charge after new request", chg_en, 1);

    // R5 low-voltage trip
    lowv_cmp = 1'b1; step(TRIP_WAIT);
    check("R5 trip fault", fault, 1);
    check("R5 trip sw", sw_en, exp_sw(0));
    lowv_cmp = 1'b0;
    power_cycle();
    check("R5 recovered", {fault, sw_en}, {1'b0, exp_sw(1)});

    // R11 clear, R9 fast shutdown
    pp_wr = 1'b1; step(1); pp_wr = 1'b0;
    check("R11 status clear", pf_stat, 0);
    fast_off = 1'b1; step(1);
    check("R9 sw off", sw_en, exp_sw(0));
    check("R9 fault and pf", {fault, pf_stat}, 2'b11);
    fast_off = 1'b0; step(UP_WAIT);
    check("R9 no return without supply cycle", sw_en, exp_sw(0));
    fast_off = 1'b1;
    uvlo_ok = 1'b0; step(2);
    check("R9 fault held while request", fault, 1);
    // R12: fault present through the whole power-up window
    uvlo_ok = 1'b1; step(UP_WAIT);
    check("R12 fault beats turn-on", sw_en, exp_sw(0));
    fast_off = 1'b0;
    power_cycle();
    check("R9 recovered", {fault, sw_en}, {1'b0, exp_sw(1)});

    // R10 three strikes
    pp_wr = 1'b1; step(1); pp_wr = 1'b0;
    for (int k = 0; k < 2; k++) begin
      pwr_fail = 1'b1; step(2); pwr_fail = 1'b0; step(2);
    end
    check("R10 two events", pf_stat, 0);
    pwr_fail = 1'b1; step(1);
    check("R10 third event", pf_stat, 1);
    pwr_fail = 1'b0; step(1);

    // R10 / R11 random events and writes against a count model
    begin
      int  m_cnt  = 0;
      bit  m_stat = 0;
      bit  m_prev = 0;
      void'($urandom(32'h5eed_1960));
      for (int i = 0; i < 400; i++) begin
        bit pf_in = ($urandom % 3) == 0 ? ~m_prev : m_prev;
        bit wr    = (i == 0) || (($urandom % 10) == 0);
        bit rise  = pf_in && !m_prev;
        if (wr) begin
          m_cnt = 0; m_stat = 0;
        end else if (rise && m_cnt < 3) begin
          m_cnt++;
          if (m_cnt == 3) m_stat = 1;
        end
        m_prev   = pf_in;
        pwr_fail = pf_in;
        pp_wr    = wr;
        step(1);
        check("R10 R11 random status", pf_stat, m_stat);
      end
      pp_wr = 1'b0;
    end

    finished = 1'b1;
    summary();
    $finish;
  end
endmodule